// File: doc/BRIEF.md
# Capture sample-rate and channel control registers

This block is the host-visible control register file for a sixteen-channel logic-capture front end. A host reaches it over a plain 8-bit register bus, with a 4-bit address, a write enable and a read-data return. Through that bus it sets up three things: which channels are captured, the divide ratio applied to a base sample clock, and which of two base clocks (a slow one near 100 MHz and a fast one near 160 MHz) feeds the divider. The block also reports whether a capture is running and whether the downstream buffer has overflowed.

Writes to the channel mask, divisor and clock-select registers only land in a staging copy. The capture logic keeps working from the committed copy until the host commits. To commit, the host writes the status/control register with its update bit set and then writes it again with the update bit clear. While the run bit is set, the block divides ticks of the selected base clock into a one-cycle sample-enable pulse. An overflow pulse from the capture buffer sets a sticky flag that stays set until the next capture start.

Top module: `smpl_ctrl_regs`

## Requirements
- R1: After reset, every register reads zero except the identifier, the committed channel mask and clock select are zero, and no sample tick or run indication is produced.
- R2: Address 7 always reads the fixed identifier 0x13, and writes to it have no effect.
- R3: Staging registers read back what was written: channel bits 7..0 at address 1, channel bits 15..8 at address 6, divisor at address 11, and base-clock select in bit 0 of address 4 (the other bits of address 4 read as zero).
- R4: The committed mask, divisor and clock select take the staged values only when address 15 is written with bit 1 (update) clear while the stored update bit is 1. A write that only sets update, or one that clears it while it is already clear, commits nothing.
- R5: While running, one sample tick is produced for every D+1 ticks of the selected base clock, where D is the committed divisor (0..255, so ratios 1..256).
- R6: With committed clock select 1 the fast base tick input is divided; with 0 the slow base tick input is divided; ticks of the unselected input are not counted.
- R7: Bit 0 of address 15 is the run bit; writing it 0 stops all sample ticks, and writing it 1 resumes them.
- R8: A pulse on the overflow input sets bit 7 of address 15. The bit stays set through a stop (writing 0 to address 15), host writes cannot set or clear it, and it clears when a write moves the run bit from 0 to 1.
- R9: When an overflow pulse and a run-starting write fall in the same cycle, the overflow bit ends up set.
- R10: Addresses 0, 2, 3, 5, 8, 9, 10, 12, 13 and 14 read as zero, and writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr |
| base_slow_tick | input | 1 | One-cycle pulse per period of the slow base clock |
| base_fast_tick | input | 1 | One-cycle pulse per period of the fast base clock |
| ovf_in | input | 1 | Overflow pulse from the capture buffer |
| chan_en_o | output | 16 | Committed channel-enable mask |
| fast_clk_sel_o | output | 1 | Committed base-clock select |
| run_o | output | 1 | Capture running |
| sample_tick_o | output | 1 | Sample-enable pulse |

## Verification
Overflow capture and capture start act on the same sticky flag, so they can land in one cycle. One clears the flag and the other sets it. The bench drives the overflow pulse on the same clock edge as the write that sets the run bit, then reads the status register and expects both the run bit and the overflow bit set (0x81). It also runs the usual order, where the start clears an earlier overflow, to show that the clear works when no overflow arrives with it.

// File: rtl/smpl_ctrl_pkg.sv
package smpl_ctrl_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam int MASK_W = 2 * DATA_W;
  localparam int DIV_W  = DATA_W;

  localparam logic [ADDR_W-1:0] A_CHLO = 4'd1;
  localparam logic [ADDR_W-1:0] A_MODE = 4'd4;
  localparam logic [ADDR_W-1:0] A_CHHI = 4'd6;
  localparam logic [ADDR_W-1:0] A_VER  = 4'd7;
  localparam logic [ADDR_W-1:0] A_DIV  = 4'd11;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd15;

  localparam int B_RUN   = 0;
  localparam int B_UPD   = 1;
  localparam int B_OVF   = 7;
  localparam int B_CKSEL = 0;

  typedef struct packed {
    logic [MASK_W-1:0] mask;
    logic [DIV_W-1:0]  div;
    logic              cksel;
  } cfg_t;
endpackage

// File: rtl/smpl_ctrl_cfg.sv
module smpl_ctrl_cfg
  import smpl_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              commit,
  output cfg_t              stg_o,
  output cfg_t              act_o
);
  cfg_t stg_q, stg_d, act_q, act_d;
  logic stg_en, act_en;

  assign stg_en = we;
  assign act_en = commit;

  always_comb begin
    stg_d = stg_q;
    case (addr)
      A_CHLO:  stg_d.mask[DATA_W-1:0]      = wdata;
      A_CHHI:  stg_d.mask[MASK_W-1:DATA_W] = wdata;
      A_DIV:   stg_d.div                   = wdata[DIV_W-1:0];
      A_MODE:  stg_d.cksel                 = wdata[B_CKSEL];
      default: stg_d                       = stg_q;
    endcase
    act_d = stg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
      act_q <= '0;
    end else begin
      if (stg_en) stg_q <= stg_d;
      if (act_en) act_q <= act_d;
    end
  end

  assign stg_o = stg_q;
  assign act_o = act_q;
endmodule

// File: rtl/smpl_ctrl_stat.sv
module smpl_ctrl_stat
  import smpl_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ovf_in,
  output logic              commit_o,
  output logic              run_o,
  output logic              upd_o,
  output logic              ovf_o
);
  logic run_q, run_d, upd_q, upd_d, ovf_q, ovf_d;
  logic wr_stat, start, ctl_en, ovf_en;

  assign wr_stat  = we && (addr == A_STAT);
  assign start    = wr_stat && wdata[B_RUN] && !run_q;
  assign commit_o = wr_stat && upd_q && !wdata[B_UPD];
  assign ctl_en   = wr_stat;
  assign ovf_en   = ovf_in || start;

  always_comb begin
    run_d = wdata[B_RUN];
    upd_d = wdata[B_UPD];
    // a set from the buffer outranks the clear from a start
    ovf_d = ovf_in ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      upd_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      if (ctl_en) begin
        run_q <= run_d;
        upd_q <= upd_d;
      end
      if (ovf_en) ovf_q <= ovf_d;
    end
  end

  assign run_o = run_q;
  assign upd_o = upd_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/smpl_ctrl_tick.sv
module smpl_ctrl_tick #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             sel_fast,
  input  logic             slow_tick,
  input  logic             fast_tick,
  input  logic [CNT_W-1:0] div,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic tick_q, tick_d, base;

  assign base = sel_fast ? fast_tick : slow_tick;

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (!run) begin
      cnt_d = '0;
    end else if (base) begin
      if (cnt_q >= div) begin
        cnt_d  = '0;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/smpl_ctrl_regs.sv
module smpl_ctrl_regs
  import smpl_ctrl_pkg::*;
#(
  parameter logic [7:0] VERSION_ID = 8'h13,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_we,
  input  logic [3:0]  host_addr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  input  logic        base_slow_tick,
  input  logic        base_fast_tick,
  input  logic        ovf_in,
  output logic [15:0] chan_en_o,
  output logic        fast_clk_sel_o,
  output logic        run_o,
  output logic        sample_tick_o
);
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic rst_int_n;
  cfg_t stg, act;
  logic commit, run_q, upd_q, ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_STAGES-1];

  smpl_ctrl_stat u_stat (
    .clk(clk), .rst_n(rst_int_n), .we(host_we), .addr(host_addr),
    .wdata(host_wdata), .ovf_in(ovf_in), .commit_o(commit),
    .run_o(run_q), .upd_o(upd_q), .ovf_o(ovf_q)
  );

  smpl_ctrl_cfg u_cfg (
    .clk(clk), .rst_n(rst_int_n), .we(host_we), .addr(host_addr),
    .wdata(host_wdata), .commit(commit), .stg_o(stg), .act_o(act)
  );

  smpl_ctrl_tick #(.CNT_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_int_n), .run(run_q), .sel_fast(act.cksel),
    .slow_tick(base_slow_tick), .fast_tick(base_fast_tick),
    .div(act.div), .tick_o(sample_tick_o)
  );

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      A_VER:  host_rdata = VERSION_ID;
      A_CHLO: host_rdata = stg.mask[DATA_W-1:0];
      A_CHHI: host_rdata = stg.mask[MASK_W-1:DATA_W];
      A_DIV:  host_rdata = stg.div;
      A_MODE: host_rdata[B_CKSEL] = stg.cksel;
      A_STAT: begin
        host_rdata[B_RUN] = run_q;
        host_rdata[B_UPD] = upd_q;
        host_rdata[B_OVF] = ovf_q;
      end
      default: host_rdata = '0;
    endcase
  end

  assign chan_en_o      = act.mask;
  assign fast_clk_sel_o = act.cksel;
  assign run_o          = run_q;
endmodule

// File: rtl/smpl_ctrl_regs_chk.sv
module smpl_ctrl_regs_chk (
  input logic        clk,
  input logic        rst_int_n,
  input logic        host_we,
  input logic [3:0]  host_addr,
  input logic [7:0]  host_wdata,
  input logic        ovf_in,
  input logic        ovf_flag,
  input logic [15:0] chan_en_o,
  input logic        fast_clk_sel_o,
  input logic        run_o,
  input logic        sample_tick_o
);
  // R4: committed settings move only right after a status write with update clear
  p_commit_only_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!$stable(chan_en_o) || !$stable(fast_clk_sel_o)) |->
      $past(host_we && host_addr == 4'd15 && !host_wdata[1]));

  // R7: a tick only follows a cycle in which the capture was running
  p_tick_gated_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    sample_tick_o |-> $past(run_o));

  // R8: the overflow flag holds unless a start occurred
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(ovf_flag) && !$rose(run_o)) |-> ovf_flag);

  // R8, R9: an overflow pulse always leaves the flag set
  p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(ovf_in) |-> ovf_flag);

  // R7: the run bit follows the last status write
  p_run_follow_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    $past(host_we && host_addr == 4'd15) |-> (run_o == $past(host_wdata[0])));
endmodule

bind smpl_ctrl_regs smpl_ctrl_regs_chk u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .host_we(host_we), .host_addr(host_addr),
  .host_wdata(host_wdata), .ovf_in(ovf_in), .ovf_flag(ovf_q),
  .chan_en_o(chan_en_o), .fast_clk_sel_o(fast_clk_sel_o), .run_o(run_o),
  .sample_tick_o(sample_tick_o)
);

// File: tb/smpl_ctrl_regs_tb_top.sv
module smpl_ctrl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        base_slow_tick = 1'b0;
  logic        base_fast_tick = 1'b0;
  logic        ovf_in = 1'b0;
  logic [15:0] chan_en_o;
  logic        fast_clk_sel_o, run_o, sample_tick_o;
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  smpl_ctrl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .base_slow_tick(base_slow_tick), .base_fast_tick(base_fast_tick),
    .ovf_in(ovf_in), .chan_en_o(chan_en_o), .fast_clk_sel_o(fast_clk_sel_o),
    .run_o(run_o), .sample_tick_o(sample_tick_o)
  );

  // {we, addr, data, expected read}
  localparam logic [20:0] VEC [0:16] = '{
    {1'b0, 4'd7,  8'h00, 8'h13},  // R2
    {1'b1, 4'd7,  8'hff, 8'h00},
    {1'b0, 4'd7,  8'h00, 8'h13},  // R2
    {1'b1, 4'd1,  8'ha5, 8'h00},
    {1'b0, 4'd1,  8'h00, 8'ha5},  // R3
    {1'b1, 4'd6,  8'h3c, 8'h00},
    {1'b0, 4'd6,  8'h00, 8'h3c},  // R3
    {1'b1, 4'd11, 8'h03, 8'h00},
    {1'b0, 4'd11, 8'h00, 8'h03},  // R3
    {1'b1, 4'd4,  8'hff, 8'h00},
    {1'b0, 4'd4,  8'h00, 8'h01},  // R3
    {1'b1, 4'd2,  8'h77, 8'h00},
    {1'b0, 4'd2,  8'h00, 8'h00},  // R10
    {1'b1, 4'd13, 8'h55, 8'h00},
    {1'b0, 4'd13, 8'h00, 8'h00},  // R10
    {1'b1, 4'd15, 8'h02, 8'h00},
    {1'b0, 4'd15, 8'h00, 8'h02}   // R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_we = 1'b0;
    #1 d = host_rdata;
  endtask

  task automatic count_ticks(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk); #1;
      if (sample_tick_o) n++;
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] r;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd(4'd15, r); chk("R1 status", r, 8'h00);
    rd(4'd1, r);  chk("R1 chlo", r, 8'h00);
    rd(4'd11, r); chk("R1 div", r, 8'h00);
    chk("R1 outputs", {chan_en_o, fast_clk_sel_o, run_o, sample_tick_o}, 19'h0);

    // vector table walk
    for (int i = 0; i < 17; i++) begin
      if (VEC[i][20]) wr(VEC[i][19:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][19:16], r);
        chk("R2/R3/R4/R10 table", r, VEC[i][7:0]);
      end
    end

    // R4: update set alone, plus ignored writes, commit nothing
    chk("R4 no commit yet", {chan_en_o, fast_clk_sel_o}, 17'h0);
    wr(4'd15, 8'h00);
    chk("R4 commit mask", chan_en_o, 16'h3ca5);
    chk("R4 commit cksel", fast_clk_sel_o, 1'b1);
    wr(4'd1, 8'h00);
    wr(4'd15, 8'h00);
    chk("R4 clear without set", chan_en_o, 16'h3ca5);
    chk("R10 outputs unaffected", {fast_clk_sel_o, run_o}, 2'b10);

    // R5, R6: fast base, ratio 4
    base_fast_tick = 1'b1; base_slow_tick = 1'b0;
    wr(4'd15, 8'h01);
    repeat (5) @(posedge clk);
    count_ticks(40, n); chk("R5 R6 ratio 4 fast", n, 10);
    base_fast_tick = 1'b0; base_slow_tick = 1'b1;
    count_ticks(40, n); chk("R6 slow ignored", n, 0);

    // R7: stop
    base_fast_tick = 1'b1;
    wr(4'd15, 8'h00);
    count_ticks(40, n); chk("R7 stopped", n, 0);
    chk("R7 run low", run_o, 1'b0);

    // R5: ratio 256 on slow base, then ratio 1
    wr(4'd11, 8'hff); wr(4'd4, 8'h00);
    wr(4'd15, 8'h02); wr(4'd15, 8'h00);
    base_fast_tick = 1'b0;
    wr(4'd15, 8'h01);
    repeat (3) @(posedge clk);
    count_ticks(512, n); chk("R5 ratio 256", n, 2);
    wr(4'd15, 8'h00);
    wr(4'd11, 8'h00);
    wr(4'd15, 8'h02); wr(4'd15, 8'h00);
    wr(4'd15, 8'h01);
    repeat (3) @(posedge clk);
    count_ticks(20, n); chk("R5 R7 ratio 1 resumed", n, 20);

    // R8: overflow sticky
    @(negedge clk); ovf_in = 1'b1; @(posedge clk); #1 ovf_in = 1'b0;
    rd(4'd15, r); chk("R8 set while running", r, 8'h81);
    wr(4'd15, 8'h00);
    rd(4'd15, r); chk("R8 kept after stop", r, 8'h80);
    wr(4'd15, 8'h00);
    rd(4'd15, r); chk("R8 host cannot clear", r, 8'h80);
    wr(4'd15, 8'h01);
    rd(4'd15, r); chk("R8 start clears", r, 8'h01);
    wr(4'd15, 8'h80);
    rd(4'd15, r); chk("R8 host cannot set", r, 8'h00);

    // R9: overflow on the same edge as a start
    @(negedge clk);
    host_addr = 4'd15; host_wdata = 8'h01; host_we = 1'b1; ovf_in = 1'b1;
    @(posedge clk); #1;
    host_we = 1'b0; ovf_in = 1'b0;
    rd(4'd15, r); chk("R9 start with overflow", r, 8'h81);

    summary();
    $finish;
  end
endmodule